// File: doc/BRIEF.md
# Timer Capture/Compare Pin Controller

This block is one channel of a general-purpose timer: the link between a general register and an I/O pin. A 4-bit mode field sets the channel's role. In compare mode the register is matched against the running counter. The pin is first set to a programmed starting level. It is then driven low, driven high or toggled on each match. In capture mode the register takes a snapshot of the counter on a chosen edge of the pin. It can instead take a snapshot whenever a companion timer channel counts.

Software writes the mode field and the register through simple write strobes. It reads both back, and clears a sticky event flag by writing a one. The counter, its count enable and the companion's count strobe come from neighbouring timer logic. The companion's 3-bit clock-select value also comes in, so the channel can refuse companion captures when that channel runs on the undivided clock.

Top module: `tmr_pin_ctl`

## Requirements
- R1: After reset the mode field, the register, the pin drive, the pin output enable and the flag are all 0.
- R2: The pin output enable is high exactly when mode bit 3 is 0 and mode bits [1:0] are not 00; whenever the enable is low, the pin drive is 0.
- R3: Writing a mode with bit 3 = 0 sets the pin level to mode bit 2 from the next cycle on.
- R4: In compare mode (bit 3 = 0) a match is the counter equal to the register while the count enable is high. On the next cycle mode bits [1:0] decide the pin: 01 drives 0, 10 drives 1, 11 toggles, 00 leaves it. A mode write in the same cycle wins over the match action.
- R5: With the count enable low, an equal counter causes no match: the pin and the flag keep their values.
- R6: With mode bits [3:2] = 10, the pin passes a two-flop synchroniser. Mode bits [1:0] pick the capture edge: 00 rising, 01 falling, 1x both. The register takes the counter value presented at the third rising clock edge after the pin changes, and edges of the other polarity are ignored.
- R7: With mode bits [3:2] = 11, the register takes the counter in every cycle the companion count strobe is high, unless the companion clock select is 000. In that case no capture happens and the register and the flag hold.
- R8: Register writes are accepted in every mode. A capture in the same cycle overrides the write.
- R9: A match or a capture sets the flag in the next cycle. A clear strobe drops it, but a set in the same cycle wins over the clear.
- R10: The mode field reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_i | input | 1 | Mode field write strobe |
| ctl_wdata_i | input | 4 | Mode field write data |
| ctl_o | output | 4 | Mode field read-back |
| gr_wr_i | input | 1 | General register write strobe |
| gr_wdata_i | input | CNT_W | General register write data |
| gr_o | output | CNT_W | General register value |
| flag_clr_i | input | 1 | Write-one clear of the event flag |
| cnt_i | input | CNT_W | Running counter value |
| cnt_en_i | input | 1 | Counter clock enable |
| pin_i | input | 1 | Pin input (asynchronous) |
| peer_evt_i | input | 1 | Companion channel count-up/down strobe |
| peer_clk_sel_i | input | 3 | Companion channel clock select |
| pin_o | output | 1 | Pin drive level |
| pin_oe_o | output | 1 | Pin output enable |
| flag_o | output | 1 | Sticky match/capture flag |

## Verification
Three collisions are the hardest to provoke: a mode write landing in the same cycle as a compare match, a capture landing on a register write, and a flag clear meeting a new event. Random stimulus keeps both the counter and the register in a range of eight values, so matches happen often. Mode writes sweep all sixteen codes, and the write, clear and strobe inputs are drawn independently so that they overlap often. Directed sequences place each collision on purpose. They also step distinct counter values across the synchroniser delay, which shows exactly which cycle's count a pin capture stores.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  localparam int CTL_W = 4;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } cmp_act_e;

  // Top bit selects capture role.
  function automatic logic mode_is_capture(input logic [CTL_W-1:0] c);
    return c[3];
  endfunction

  // Output enabled for compare codes that act on a match.
  function automatic logic oe_from_mode(input logic [CTL_W-1:0] c);
    return !c[3] && (c[1:0] != 2'b00);
  endfunction

  function automatic logic level_after_match(input logic [1:0] act, input logic cur);
    case (cmp_act_e'(act))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return !cur;
      default:    return cur;
    endcase
  endfunction

  // 00 rising, 01 falling, 1x both.
  function automatic logic edge_selected(input logic [1:0] sel, input logic rise,
                                         input logic fall);
    case (sel)
      2'b00:   return rise;
      2'b01:   return fall;
      default: return rise | fall;
    endcase
  endfunction

endpackage

// File: rtl/tpc_edge_sync.sv
module tpc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous value.
  logic [STAGES:0] chain;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
  assign fall_o = ~chain[STAGES-1] & chain[STAGES];

  assert_edges_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));

endmodule

// File: rtl/tpc_cmp_out.sv
module tpc_cmp_out
  import tpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] mode_i,
  input  logic             mode_wr_i,
  input  logic [CTL_W-1:0] mode_wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] gr_i,
  output logic             pin_o,
  output logic             oe_o,
  output logic             match_o
);
  logic level_q;
  logic level_d;
  logic init_load;

  assign match_o   = !mode_is_capture(mode_i) && cnt_en_i && (cnt_i == gr_i);
  assign init_load = mode_wr_i && !mode_is_capture(mode_wdata_i);

  always_comb begin
    level_d = level_q;
    if (init_load)    level_d = mode_wdata_i[2];
    else if (match_o) level_d = level_after_match(mode_i[1:0], level_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign oe_o  = oe_from_mode(mode_i);
  assign pin_o = oe_o & level_q;

  assert_init_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |=> level_q == $past(mode_wdata_i[2]));

  assert_no_match_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en_i |-> !match_o);

  assert_toggle_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !mode_wr_i && mode_i[1:0] == 2'b11) |=> level_q != $past(level_q));

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> !pin_o);

endmodule

// File: rtl/tpc_cap_reg.sv
module tpc_cap_reg
  import tpc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] mode_i,
  input  logic             pin_rise_i,
  input  logic             pin_fall_i,
  input  logic             peer_evt_i,
  input  logic [SEL_W-1:0] peer_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] gr_o,
  output logic             cap_o
);
  logic [CNT_W-1:0] gr_q;
  logic             pin_cap;
  logic             peer_cap;
  logic             peer_usable;

  assign peer_usable = (peer_sel_i != '0);
  assign pin_cap  = (mode_i[3:2] == 2'b10) && edge_selected(mode_i[1:0], pin_rise_i, pin_fall_i);
  assign peer_cap = (mode_i[3:2] == 2'b11) && peer_evt_i && peer_usable;
  assign cap_o    = pin_cap | peer_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gr_q <= '0;
    else if (cap_o) gr_q <= cnt_i;
    else if (wr_i)  gr_q <= wdata_i;
  end

  assign gr_o = gr_q;

  assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> gr_q == $past(cnt_i));

  assert_peer_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[3:2] == 2'b11 && peer_sel_i == '0 && !wr_i) |=> $stable(gr_q));

  assert_write_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !cap_o) |=> gr_q == $past(wdata_i));

endmodule

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl
  import tpc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_i,
  input  logic [3:0]       ctl_wdata_i,
  output logic [3:0]       ctl_o,
  input  logic             gr_wr_i,
  input  logic [CNT_W-1:0] gr_wdata_i,
  output logic [CNT_W-1:0] gr_o,
  input  logic             flag_clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_en_i,
  input  logic             pin_i,
  input  logic             peer_evt_i,
  input  logic [2:0]       peer_clk_sel_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             flag_o
);
  localparam int SEL_W = 3;

  logic [CTL_W-1:0] ctl_q;
  logic             flag_q;
  logic             match_w;
  logic             cap_w;
  logic             rise_w;
  logic             fall_w;
  logic [CNT_W-1:0] gr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= '0;
    else if (ctl_wr_i) ctl_q <= ctl_wdata_i;
  end

  tpc_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (pin_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  tpc_cap_reg #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (ctl_q),
    .pin_rise_i (rise_w),
    .pin_fall_i (fall_w),
    .peer_evt_i (peer_evt_i),
    .peer_sel_i (peer_clk_sel_i),
    .cnt_i      (cnt_i),
    .wr_i       (gr_wr_i),
    .wdata_i    (gr_wdata_i),
    .gr_o       (gr_w),
    .cap_o      (cap_w)
  );

  tpc_cmp_out #(.CNT_W(CNT_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (ctl_q),
    .mode_wr_i    (ctl_wr_i),
    .mode_wdata_i (ctl_wdata_i),
    .cnt_i        (cnt_i),
    .cnt_en_i     (cnt_en_i),
    .gr_i         (gr_w),
    .pin_o        (pin_o),
    .oe_o         (pin_oe_o),
    .match_o      (match_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (match_w || cap_w) flag_q <= 1'b1;
    else if (flag_clr_i)       flag_q <= 1'b0;
  end

  assign ctl_o  = ctl_q;
  assign gr_o   = gr_w;
  assign flag_o = flag_q;

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_w || cap_w) |=> flag_o);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !match_w && !cap_w) |=> !flag_o);

  assert_roles_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_w && cap_w));

  assert_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i |=> ctl_o == $past(ctl_wdata_i));

endmodule

// File: tb/tmr_pin_ctl_tb_top.sv
`timescale 1ns/1ps
module tmr_pin_ctl_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_wr = 1'b0;
  logic [3:0]   ctl_wd = '0;
  logic [3:0]   ctl_rd;
  logic         gr_wr = 1'b0;
  logic [W-1:0] gr_wd = '0;
  logic [W-1:0] gr_rd;
  logic         flag_clr = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         cnt_en = 1'b0;
  logic         pin_in = 1'b0;
  logic         peer_evt = 1'b0;
  logic [2:0]   peer_sel = '0;
  logic         pin_out, pin_oe, flag;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tmr_pin_ctl #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd), .ctl_o(ctl_rd),
    .gr_wr_i(gr_wr), .gr_wdata_i(gr_wd), .gr_o(gr_rd), .flag_clr_i(flag_clr),
    .cnt_i(cnt), .cnt_en_i(cnt_en), .pin_i(pin_in), .peer_evt_i(peer_evt),
    .peer_clk_sel_i(peer_sel), .pin_o(pin_out), .pin_oe_o(pin_oe), .flag_o(flag)
  );

  // Reference model written from the requirements.
  logic [3:0]   m_ctl;
  logic [W-1:0] m_gr;
  logic         m_lvl, m_flag, m_a, m_b, m_c;

  function automatic logic exp_oe(input logic [3:0] c);
    return (c[3] == 1'b0) && (c[1:0] != 2'b00);
  endfunction

  function automatic logic exp_edge(input logic [1:0] s, input logic now, input logic old);
    if (s == 2'b00) return now && !old;
    if (s == 2'b01) return !now && old;
    return now != old;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0; m_gr = '0; m_lvl = 0; m_flag = 0; m_a = 0; m_b = 0; m_c = 0;
    end else begin
      automatic logic match = !m_ctl[3] && cnt_en && (cnt == m_gr);
      automatic logic cap = (m_ctl[3:2] == 2'b10 && exp_edge(m_ctl[1:0], m_b, m_c)) ||
                            (m_ctl[3:2] == 2'b11 && peer_evt && peer_sel != 3'd0);
      if (ctl_wr && !ctl_wd[3]) m_lvl = ctl_wd[2];
      else if (match) begin
        case (m_ctl[1:0])
          2'b01: m_lvl = 1'b0;
          2'b10: m_lvl = 1'b1;
          2'b11: m_lvl = !m_lvl;
          default: ;
        endcase
      end
      if (cap) m_gr = cnt; else if (gr_wr) m_gr = gr_wd;
      if (match || cap) m_flag = 1'b1; else if (flag_clr) m_flag = 1'b0;
      if (ctl_wr) m_ctl = ctl_wd;
      m_c = m_b; m_b = m_a; m_a = pin_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    ctl_wr = 0; gr_wr = 0; flag_clr = 0;
  endtask

  task automatic model_cmp();
    chk("R10 ctl_o", ctl_rd, m_ctl);
    chk("R2 pin_oe_o", pin_oe, exp_oe(m_ctl));
    chk("R4 pin_o", pin_out, exp_oe(m_ctl) & m_lvl);
    chk("R8 gr_o", gr_rd, m_gr);
    chk("R9 flag_o", flag, m_flag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 ctl", ctl_rd, 0); chk("R1 gr", gr_rd, 0); chk("R1 pin", pin_out, 0);
    chk("R1 oe", pin_oe, 0); chk("R1 flag", flag, 0);

    // R3 initial level 1, action drive 0
    ctl_wr = 1; ctl_wd = 4'b0101; gr_wr = 1; gr_wd = 16'd5; cnt = 0; cnt_en = 0;
    tick(); idle();
    chk("R3 init level", pin_out, 1); chk("R2 oe on", pin_oe, 1); chk("R8 write", gr_rd, 5);
    cnt = 16'd5; cnt_en = 0; tick();
    chk("R5 no match pin", pin_out, 1); chk("R5 no match flag", flag, 0);
    cnt_en = 1; tick();
    chk("R4 drive low", pin_out, 0); chk("R9 flag set", flag, 1);
    cnt_en = 0; flag_clr = 1; tick(); idle();
    chk("R9 flag cleared", flag, 0);
    cnt_en = 1; flag_clr = 1; tick(); idle();
    chk("R9 set beats clear", flag, 1);
    // R4 mode write beats match action (init 1 vs drive 0)
    ctl_wr = 1; ctl_wd = 4'b0111; tick(); idle();
    chk("R4 write beats match", pin_out, 1);
    cnt_en = 1; tick();
    chk("R4 toggle", pin_out, 0);
    cnt_en = 0; ctl_wr = 1; ctl_wd = 4'b0100; tick(); idle();
    chk("R2 disabled oe", pin_oe, 0); chk("R2 disabled pin", pin_out, 0);

    // R6 rising capture timing
    ctl_wr = 1; ctl_wd = 4'b1000; flag_clr = 1; pin_in = 0; tick(); idle();
    repeat (3) tick();
    pin_in = 1; cnt = 16'h00A1; tick();
    cnt = 16'h00B2; tick();
    cnt = 16'h00C3; tick();
    chk("R6 capture cycle", gr_rd, 16'h00C3); chk("R9 capture flag", flag, 1);
    cnt = 16'h00D4; tick();
    chk("R6 single capture", gr_rd, 16'h00C3);
    pin_in = 0; flag_clr = 1;
    for (int i = 0; i < 4; i++) begin cnt = 16'h0100 + 16'(i); tick(); flag_clr = 0; end
    chk("R6 falling ignored", gr_rd, 16'h00C3); chk("R6 no flag", flag, 0);

    // R7 companion source
    ctl_wr = 1; ctl_wd = 4'b1100; tick(); idle();
    peer_sel = 3'd0; peer_evt = 1; cnt = 16'h0077; tick(); tick();
    chk("R7 blocked gr", gr_rd, 16'h00C3); chk("R7 blocked flag", flag, 0);
    peer_sel = 3'd3; tick();
    chk("R7 peer capture", gr_rd, 16'h0077);
    // R8 capture over write
    peer_sel = 3'd1; gr_wr = 1; gr_wd = 16'hAAAA; cnt = 16'h0055; tick();
    chk("R8 capture wins", gr_rd, 16'h0055);
    peer_evt = 0; tick(); idle();
    chk("R8 write in capture mode", gr_rd, 16'hAAAA);
    chk("R10 readback", ctl_rd, 4'hC);

    // Constrained random phase against the model
    for (int n = 0; n < 4000; n++) begin
      model_cmp();
      ctl_wr   = ($urandom_range(0, 15) == 0);
      ctl_wd   = 4'($urandom_range(0, 15));
      gr_wr    = ($urandom_range(0, 7) == 0);
      gr_wd    = 16'($urandom_range(0, 7));
      flag_clr = ($urandom_range(0, 5) == 0);
      cnt      = 16'($urandom_range(0, 7));
      cnt_en   = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 3) == 0) pin_in = !pin_in;
      peer_evt = ($urandom_range(0, 2) == 0);
      peer_sel = 3'($urandom_range(0, 7));
      tick();
    end
    model_cmp();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule